// File: doc/BRIEF.md
# Stream-to-Memory Burst Write Engine

This block moves one packet or byte run from a streaming source into memory. A descriptor gives a word-aligned start address, a byte length and a flag that lets the end of the packet close the transfer early. Incoming stream words go into an internal FIFO. A write side drains the FIFO as memory-mapped write bursts. Each word carries byte enables, so a transfer can be any number of bytes long.

To suit memories that wrap bursts, the write side issues single-beat writes until the address sits on a boundary of (maximum burst × word bytes). From there it uses full bursts, and the last burst is cut to the words that remain. The engine counts bursts that are still waiting for a write response. It raises its one-cycle completion pulse only when that count is zero. The pulse reports the number of bytes written and the OR of every error code seen on the stream during the transfer.

Top module: `s2m_burst_writer`

## Requirements
- R1: A descriptor is taken only while `desc_ready` is high, which means idle. `st_ready` stays low when idle and after the transfer's final word has been taken, so no further stream word is consumed.
- R2: While the current write address is not a multiple of MAX_BURST×(DATA_W/8) bytes, every burst has a burstcount of 1.
- R3: From an aligned address, the burstcount is the smaller of MAX_BURST and the number of words left. A burst never goes past the transfer's last word.
- R4: `m_write` stays high on every beat of a burst. Address and burstcount hold steady while `m_waitrequest` is high. Progress advances only on beats taken with `m_waitrequest` low.
- R5: A burst begins only when the FIFO already holds all of its words. The stream is back-pressured when the FIFO is full, and no data is lost.
- R6: The engine counts bursts awaiting a write response: +1 on each burst's first accepted beat, −1 on each `m_resp_valid`. `done_pulse` fires only when all words are written and that count is zero.
- R7: Byte enables are all ones except on the final word of a length-bounded transfer. There, lanes 0 to (length mod word bytes)−1 are set. A remainder of 0 sets all lanes.
- R8: With end-on-EOP set, an EOP word ends the transfer. Its lanes below (word bytes − `st_empty`) are enabled, and the reported byte count is words×word bytes − `st_empty`. If the length runs out first, the length rules apply.
- R9: With end-on-EOP clear, EOP and empty have no effect. The programmed length alone decides the words and bytes written.
- R10: `done_error` is the OR of `st_error` over all stream words taken in this transfer. It is cleared when a new descriptor is taken.
- R11: In a length-bounded transfer, `done_bytes` equals the programmed length.
- R12: After reset, `desc_ready` is 1, and `m_write`, `st_ready` and `done_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Word-aligned start byte address |
| desc_len | input | LEN_W | Transfer length in bytes |
| desc_eop_end | input | 1 | Let EOP end the transfer early |
| st_data | input | DATA_W | Stream data, lane 0 in the low byte |
| st_valid | input | 1 | Stream word valid |
| st_ready | output | 1 | Stream word taken this cycle when valid |
| st_sop | input | 1 | First word of a packet |
| st_eop | input | 1 | Last word of a packet |
| st_empty | input | log2(DATA_W/8) | Unused high lanes in the EOP word |
| st_error | input | ERR_W | Error code attached to the word |
| m_address | output | ADDR_W | Burst start byte address |
| m_burstcount | output | log2(MAX_BURST)+1 | Beats in the current burst |
| m_byteenable | output | DATA_W/8 | Lane enables of the current beat |
| m_writedata | output | DATA_W | Data of the current beat |
| m_write | output | 1 | Write beat valid |
| m_waitrequest | input | 1 | Memory stalls the current beat |
| m_resp_valid | input | 1 | One write response (one per burst) |
| done_pulse | output | 1 | One-cycle transfer completion |
| done_bytes | output | LEN_W | Bytes written, valid with done_pulse |
| done_error | output | ERR_W | OR of stream errors, valid with done_pulse |

## Verification
The bench sweeps each word offset inside a burst boundary against every length from 1 to 20 bytes. For each transfer it predicts the exact burst sequence. A design that skipped the single-beat lead-in, or let the last burst overrun, shows up as a burstcount mismatch and as bytes written past the end of a pre-filled memory image. EOP-terminated packets with every empty value check the short final word and the reduced byte count. A packet whose EOP arrives in the middle with end-on-EOP clear must be ignored. Random stalls, slow responses and a long transfer against a heavily stalled memory show whether completion races ahead of outstanding responses, or whether a full FIFO drops or repeats words.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    // How the word being taken from the stream closes the transfer.
    typedef enum logic [1:0] {
        LAST_NONE   = 2'd0,
        LAST_BY_LEN = 2'd1,
        LAST_BY_EOP = 2'd2
    } s2m_last_e;
endpackage

// File: rtl/s2m_fifo.sv
module s2m_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = s_q.wr + AW'(1);
        if (pop)  s_d.rd = s_q.rd + AW'(1);
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wr] <= wdata;
    end

    assign rdata = mem_q[s_q.rd];
    assign count = s_q.cnt;

    // The intake never pushes into a full FIFO.
    assert_fifo_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt < CW'(DEPTH)));

    // The write side only pops a word that is present.
    assert_fifo_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt != '0));
endmodule

// File: rtl/s2m_intake.sv
module s2m_intake
    import s2m_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int ERR_W  = 2,
    localparam int BYTES = DATA_W / 8,
    localparam int LB    = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_eop_end,
    input  logic              st_valid,
    input  logic              st_sop,
    input  logic              st_eop,
    input  logic [LB-1:0]     st_empty,
    input  logic [ERR_W-1:0]  st_error,
    input  logic              fifo_full,
    input  logic              fin,
    output logic              desc_ready,
    output logic              start,
    output logic              st_ready,
    output logic              push,
    output logic [BYTES-1:0]  push_be,
    output logic              busy,
    output logic              fill_done,
    output logic [LEN_W-1:0]  total_words,
    output logic [LEN_W-1:0]  xfer_bytes,
    output logic [ERR_W-1:0]  xfer_err
);
    typedef struct packed {
        logic             busy;
        logic             fill_done;
        logic             eop_end;
        logic [LB-1:0]    len_rem;
        logic [LEN_W-1:0] total;
        logic [LEN_W-1:0] pushed;
        logic [LEN_W-1:0] bytes;
        logic [ERR_W-1:0] err;
    } in_st_t;

    in_st_t s_d, s_q;

    logic [LEN_W:0]   words_wide;
    logic [LEN_W-1:0] words;
    logic [LEN_W-1:0] nxt;
    logic [LEN_W-1:0] eop_bytes;
    logic [LB:0]      eop_lanes;
    logic [BYTES-1:0] be_len, be_eop;
    logic             acc;
    s2m_last_e        last_kind;

    always_comb begin
        s_d        = s_q;
        start      = desc_valid && !s_q.busy;
        st_ready   = s_q.busy && !s_q.fill_done && !fifo_full;
        acc        = st_valid && st_ready;
        words_wide = {1'b0, desc_len} + (LEN_W+1)'(BYTES - 1);
        words      = LEN_W'(words_wide >> LB);
        nxt        = s_q.pushed + LEN_W'(1);
        eop_bytes  = (nxt << LB) - LEN_W'(st_empty);
        eop_lanes  = (LB+1)'(BYTES) - (LB+1)'(st_empty);
        for (int i = 0; i < BYTES; i++) begin
            be_len[i] = (s_q.len_rem == '0) || (i < int'(s_q.len_rem));
            be_eop[i] = (i < int'(eop_lanes));
        end

        if (nxt == s_q.total)          last_kind = LAST_BY_LEN;
        else if (s_q.eop_end && st_eop) last_kind = LAST_BY_EOP;
        else                            last_kind = LAST_NONE;

        push_be = '1;
        if (acc) begin
            s_d.pushed = nxt;
            s_d.err    = s_q.err | st_error;
            case (last_kind)
                LAST_BY_LEN: begin
                    s_d.fill_done = 1'b1;
                    push_be       = be_len;
                end
                LAST_BY_EOP: begin
                    s_d.fill_done = 1'b1;
                    s_d.total     = nxt;
                    s_d.bytes     = eop_bytes;
                    push_be       = be_eop;
                end
                default: ;
            endcase
        end

        if (start) begin
            s_d.busy      = 1'b1;
            s_d.fill_done = (words == '0);
            s_d.eop_end   = desc_eop_end;
            s_d.len_rem   = desc_len[LB-1:0];
            s_d.total     = words;
            s_d.pushed    = '0;
            s_d.bytes     = desc_len;
            s_d.err       = '0;
        end

        if (fin) begin
            s_d.busy      = 1'b0;
            s_d.fill_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign push        = acc;
    assign desc_ready  = !s_q.busy;
    assign busy        = s_q.busy;
    assign fill_done   = s_q.fill_done;
    assign total_words = s_q.total;
    assign xfer_bytes  = s_q.bytes;
    assign xfer_err    = s_q.err;

    // Packet framing: in end-on-EOP mode the first word taken opens a packet.
    assert_sop_opens_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && s_q.eop_end && s_q.pushed == '0) |-> st_sop);
endmodule

// File: rtl/s2m_issue.sv
module s2m_issue #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 4,
    parameter int CW        = 5,
    localparam int BYTES    = DATA_W / 8,
    localparam int BC_W     = $clog2(MAX_BURST) + 1,
    localparam int AL_W     = $clog2(MAX_BURST * BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic              busy,
    input  logic              fill_done,
    input  logic [LEN_W-1:0]  total_words,
    input  logic [CW-1:0]     fifo_count,
    input  logic              m_waitrequest,
    input  logic              m_resp_valid,
    output logic              pop,
    output logic [ADDR_W-1:0] m_address,
    output logic [BC_W-1:0]   m_burstcount,
    output logic              m_write,
    output logic              fin
);
    typedef struct packed {
        logic [ADDR_W-1:0] cur_addr;
        logic [ADDR_W-1:0] baddr;
        logic [LEN_W-1:0]  written;
        logic [BC_W-1:0]   left;
        logic [BC_W-1:0]   bcount;
        logic [LEN_W-1:0]  outst;
    } is_st_t;

    is_st_t s_d, s_q;

    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] blen;
    logic             aligned, beat, first, launch;

    always_comb begin
        s_d     = s_q;
        rem     = total_words - s_q.written;
        aligned = (s_q.cur_addr[AL_W-1:0] == '0);
        if (!aligned)                        blen = LEN_W'(1);
        else if (rem < LEN_W'(MAX_BURST))    blen = rem;
        else                                 blen = LEN_W'(MAX_BURST);

        m_write = (s_q.left != '0);
        beat    = m_write && !m_waitrequest;
        first   = (s_q.left == s_q.bcount);
        launch  = busy && !m_write && (rem != '0) && (LEN_W'(fifo_count) >= blen);
        fin     = busy && fill_done && (rem == '0) && !m_write && (s_q.outst == '0);

        if (beat) begin
            s_d.cur_addr = s_q.cur_addr + ADDR_W'(BYTES);
            s_d.written  = s_q.written + LEN_W'(1);
            s_d.left     = s_q.left - BC_W'(1);
        end

        case ({beat && first, m_resp_valid})
            2'b10:   s_d.outst = s_q.outst + LEN_W'(1);
            2'b01:   s_d.outst = s_q.outst - LEN_W'(1);
            default: s_d.outst = s_q.outst;
        endcase

        if (launch) begin
            s_d.left   = BC_W'(blen);
            s_d.bcount = BC_W'(blen);
            s_d.baddr  = s_q.cur_addr;
        end

        if (start) begin
            s_d.cur_addr = desc_addr;
            s_d.written  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pop          = beat;
    assign m_address    = s_q.baddr;
    assign m_burstcount = s_q.bcount;

    assert_misaligned_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && first && (m_address[AL_W-1:0] != '0)) |-> (m_burstcount == BC_W'(1)));

    assert_burst_within_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_write |-> ((m_burstcount != '0) && (m_burstcount <= BC_W'(MAX_BURST))));

    assert_hold_on_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_waitrequest) |=> (m_write && $stable(m_address) && $stable(m_burstcount)));

    assert_resp_tracked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_resp_valid |-> (s_q.outst != '0));
endmodule

// File: rtl/s2m_burst_writer.sv
module s2m_burst_writer #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_BURST  = 4,
    parameter int ERR_W      = 2,
    localparam int BYTES     = DATA_W / 8,
    localparam int LB        = $clog2(BYTES),
    localparam int BC_W      = $clog2(MAX_BURST) + 1,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1,
    localparam int FW        = DATA_W + BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_eop_end,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic              st_sop,
    input  logic              st_eop,
    input  logic [LB-1:0]     st_empty,
    input  logic [ERR_W-1:0]  st_error,
    output logic [ADDR_W-1:0] m_address,
    output logic [BC_W-1:0]   m_burstcount,
    output logic [BYTES-1:0]  m_byteenable,
    output logic [DATA_W-1:0] m_writedata,
    output logic              m_write,
    input  logic              m_waitrequest,
    input  logic              m_resp_valid,
    output logic              done_pulse,
    output logic [LEN_W-1:0]  done_bytes,
    output logic [ERR_W-1:0]  done_error
);
    // DATA_W >= 16; MAX_BURST <= FIFO_DEPTH/4; CW <= LEN_W.
    logic             start, push, pop, busy, fill_done, fin, fifo_full;
    logic [BYTES-1:0] push_be;
    logic [LEN_W-1:0] total_words;
    logic [CW-1:0]    fifo_count;
    logic [FW-1:0]    head;

    assign fifo_full = (fifo_count == CW'(FIFO_DEPTH));

    s2m_intake #(.DATA_W(DATA_W), .LEN_W(LEN_W), .ERR_W(ERR_W)) u_intake (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_len(desc_len), .desc_eop_end(desc_eop_end),
        .st_valid(st_valid), .st_sop(st_sop), .st_eop(st_eop),
        .st_empty(st_empty), .st_error(st_error),
        .fifo_full(fifo_full), .fin(fin),
        .desc_ready(desc_ready), .start(start), .st_ready(st_ready),
        .push(push), .push_be(push_be), .busy(busy), .fill_done(fill_done),
        .total_words(total_words), .xfer_bytes(done_bytes), .xfer_err(done_error)
    );

    s2m_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata({push_be, st_data}),
        .pop(pop), .rdata(head), .count(fifo_count)
    );

    s2m_issue #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                .MAX_BURST(MAX_BURST), .CW(CW)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .start(start), .desc_addr(desc_addr), .busy(busy), .fill_done(fill_done),
        .total_words(total_words), .fifo_count(fifo_count),
        .m_waitrequest(m_waitrequest), .m_resp_valid(m_resp_valid),
        .pop(pop), .m_address(m_address), .m_burstcount(m_burstcount),
        .m_write(m_write), .fin(fin)
    );

    assign m_writedata  = head[DATA_W-1:0];
    assign m_byteenable = head[FW-1:DATA_W];
    assign done_pulse   = fin;
endmodule

// File: tb/tb_s2m_burst_writer.sv
module tb_s2m_burst_writer;
    localparam int BY   = 4;
    localparam int MAXB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0, desc_eop_end = 1'b0;
    logic [31:0] desc_addr = '0;
    logic [15:0] desc_len = '0;
    logic [31:0] st_data = '0;
    logic        st_valid = 1'b0, st_sop = 1'b0, st_eop = 1'b0;
    logic [1:0]  st_empty = '0, st_error = '0;
    logic        m_waitrequest = 1'b0, m_resp_valid = 1'b0;
    logic        desc_ready, st_ready, m_write, done_pulse;
    logic [31:0] m_address, m_writedata;
    logic [2:0]  m_burstcount;
    logic [3:0]  m_byteenable;
    logic [15:0] done_bytes;
    logic [1:0]  done_error;

    always #2 clk = ~clk;

    s2m_burst_writer dut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
        .desc_len(desc_len), .desc_eop_end(desc_eop_end),
        .st_data(st_data), .st_valid(st_valid), .st_ready(st_ready),
        .st_sop(st_sop), .st_eop(st_eop), .st_empty(st_empty), .st_error(st_error),
        .m_address(m_address), .m_burstcount(m_burstcount), .m_byteenable(m_byteenable),
        .m_writedata(m_writedata), .m_write(m_write), .m_waitrequest(m_waitrequest),
        .m_resp_valid(m_resp_valid),
        .done_pulse(done_pulse), .done_bytes(done_bytes), .done_error(done_error)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    int wait_level = 0;

    logic [7:0] mem [0:511];
    int got_ba [0:63];
    int got_bc [0:63];
    int nb = 0, beat = 0, cur_ba = 0;
    int bursts_done = 0, resps_sent = 0;
    bit done_seen = 0;
    int d_bytes = 0, d_err = 0, d_acc = 0, d_bursts = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int tag, input int i);
        return 8'(tag * 37 + i * 5 + 1);
    endfunction

    // Memory stalls and write responses.
    always @(negedge clk) begin
        case (wait_level)
            0: m_waitrequest = 1'b0;
            1: m_waitrequest = ($urandom % 4) == 0;
            default: m_waitrequest = ($urandom % 8) != 0;
        endcase
        if (bursts_done > resps_sent && ($urandom % 3) == 0) begin
            m_resp_valid = 1'b1;
            resps_sent++;
        end else begin
            m_resp_valid = 1'b0;
        end
    end

    // Bus and completion monitor, sampled between edges.
    always @(negedge clk) begin
        #1;
        if (rst_n && m_write && !m_waitrequest) begin
            if (beat == 0) begin
                cur_ba = int'(m_address);
                if (nb < 64) begin
                    got_ba[nb] = int'(m_address);
                    got_bc[nb] = int'(m_burstcount);
                end
                nb++;
            end
            for (int i = 0; i < BY; i++)
                if (m_byteenable[i]) mem[(cur_ba + beat * BY + i) & 511] = m_writedata[8*i +: 8];
            beat++;
            if (beat >= int'(m_burstcount)) begin
                beat = 0;
                bursts_done++;
            end
        end
        if (rst_n && done_pulse) begin
            done_seen = 1;
            d_bytes   = int'(done_bytes);
            d_err     = int'(done_error);
            d_acc     = resps_sent - int'(m_resp_valid);
            d_bursts  = bursts_done;
        end
    end

    task automatic send(input int nwords, input int eop_at, input int empty, input int err_at, input int tag);
        for (int k = 0; k < nwords; ) begin
            @(negedge clk);
            st_valid = ($urandom % 4) != 0;
            for (int b = 0; b < BY; b++) st_data[8*b +: 8] = pat(tag, k * BY + b);
            st_sop   = (k == 0);
            st_eop   = (k == eop_at);
            st_empty = (k == eop_at) ? 2'(empty) : 2'd0;
            st_error = (k == err_at) ? 2'b10 : 2'b00;
            #1;
            if (st_valid && st_ready) k++;
        end
        @(negedge clk);
        st_valid = 1'b0;
        st_eop   = 1'b0;
    endtask

    task automatic xfer(input int addr, input int len, input bit eop_end, input int nwords,
                        input int eop_at, input int empty, input int err_at, input int tag,
                        input int exp_bytes, input string req);
        int exp_bc [0:63];
        int enb, a, w, b, bad, exp_err;
        for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
        nb = 0; beat = 0; done_seen = 0;
        exp_err = (err_at >= 0) ? 2 : 0;
        enb = 0; a = addr; w = (exp_bytes + BY - 1) / BY;
        while (w > 0) begin
            if (a % (MAXB * BY) != 0) b = 1;
            else b = (w < MAXB) ? w : MAXB;
            exp_bc[enb] = b; enb++;
            a += b * BY; w -= b;
        end

        @(negedge clk);
        desc_valid = 1'b1; desc_addr = 32'(addr); desc_len = 16'(len); desc_eop_end = eop_end;
        #1;
        chk(desc_ready == 1'b1, "R1", "desc_ready when idle", int'(desc_ready), 1);
        @(negedge clk);
        desc_valid = 1'b0;
        #1;
        chk(desc_ready == 1'b0, "R1", "desc_ready while busy", int'(desc_ready), 0);

        send(nwords, eop_at, empty, err_at, tag);
        for (int c = 0; c < 20000 && !done_seen; c++) @(negedge clk);
        chk(done_seen, "R6", "completion seen", int'(done_seen), 1);
        chk(d_acc == d_bursts, "R6", "responses before done", d_acc, d_bursts);
        chk(d_bytes == exp_bytes, req, "done_bytes", d_bytes, exp_bytes);
        chk(d_err == exp_err, "R10", "done_error", d_err, exp_err);
        chk(nb == enb, "R3", "burst count", nb, enb);
        bad = 0;
        for (int i = 0; i < enb && i < nb && i < 64; i++) if (got_bc[i] != exp_bc[i]) bad++;
        chk(bad == 0, "R2", "burst length mismatches", bad, 0);
        bad = 0;
        for (int i = 0; i < enb && i < nb && i < 64; i++)
            if (got_ba[i] % (MAXB * BY) != 0 && got_bc[i] != 1) bad++;
        chk(bad == 0, "R2", "multi-beat from misaligned address", bad, 0);
        bad = 0;
        for (int i = addr - 8; i < addr + len + 8 && i < 512; i++) begin
            if (i >= addr && i < addr + exp_bytes) begin
                if (mem[i] != pat(tag, i - addr)) bad++;
            end else if (mem[i] != 8'hEE) bad++;
        end
        chk(bad == 0, "R7", "memory image byte mismatches", bad, 0);
        @(negedge clk);
        #1;
        chk(st_ready == 1'b0 && desc_ready == 1'b1, "R1", "stream closed after done",
            int'(st_ready), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int tag;
        repeat (4) @(negedge clk);
        #1;
        chk(desc_ready == 1'b1, "R12", "reset desc_ready", int'(desc_ready), 1);
        chk(m_write == 1'b0, "R12", "reset m_write", int'(m_write), 0);
        chk(st_ready == 1'b0, "R12", "reset st_ready", int'(st_ready), 0);
        chk(done_pulse == 1'b0, "R12", "reset done_pulse", int'(done_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tag = 1;

        // R2 R3 R7 R11: every word offset against every length 1..20.
        wait_level = 1;
        for (int off = 0; off < MAXB; off++)
            for (int len = 1; len <= 20; len++) begin
                xfer(64 + off * BY, len, 1'b0, (len + BY - 1) / BY, -1, 0,
                     (len % 5 == 0) ? 0 : -1, tag, len, "R11");
                tag++;
            end

        // R8: packet ends at EOP with every empty value.
        for (int k = 1; k <= 5; k++)
            for (int e = 0; e < BY; e++) begin
                xfer(64 + (k % MAXB) * BY, 64, 1'b1, k, k - 1, e, -1, tag, k * BY - e, "R8");
                tag++;
            end

        // R8: length runs out before any EOP.
        xfer(68, 6, 1'b1, 2, -1, 0, -1, tag, 6, "R8"); tag++;

        // R9: mid-packet EOP ignored when end-on-EOP is clear.
        xfer(72, 13, 1'b0, 4, 1, 3, 2, tag, 13, "R9"); tag++;

        // R5: long transfer against a heavily stalled memory fills the FIFO.
        wait_level = 2;
        xfer(68, 202, 1'b0, 51, -1, 0, -1, tag, 202, "R5"); tag++;
        wait_level = 0;
        xfer(64, 40, 1'b0, 10, -1, 0, 3, tag, 40, "R4"); tag++;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule